// File: doc/BRIEF.md
# Processor-to-ISA I/O Window Translator

This block sits on a 32-bit processor memory bus and turns accesses that fall inside an 8 MB I/O window into transactions on an ISA-style I/O port bus. Each claimed processor access becomes exactly one port-bus transaction carrying a 16-bit port number, a byte count of 1, 2 or 4, and right-justified data. The processor waits, with its ready signal low, until the port bus acknowledges.

A mode input chooses how window offsets become port numbers. In contiguous mode the low 16 bits of the offset are the port. In sparse mode each 4 KB processor page is folded onto a 32-byte group of ports. Software can then give each small group of ports its own page and protect it on its own. Data lanes on the processor side follow little-endian order, so the byte at address offset k within a word travels on bits [8k+7:8k].

A second, 4-byte region decodes interrupt acknowledge. A read at its 16-byte-aligned first byte sends a one-cycle request to the interrupt controller and returns the vector it supplies. Every other access in that region completes at once, reading zero or discarding the write. Addresses outside both regions are left unclaimed.

Top module: `isa_io_bridge`

## Requirements
- R1: An access with cpu_addr in 0x80000000..0x807FFFFF is claimed and produces exactly one port-bus transaction; no interrupt request is raised for it.
- R2: With map_sparse low at acceptance, io_port equals bits [15:0] of the window offset (cpu_addr[22:0]).
- R3: With map_sparse high at acceptance, io_port equals {offset[22:12], offset[4:0]}: offset bits [22:12] appear at port bits [15:5] and offset bits [4:0] at port bits [4:0].
- R4: cpu_size code 0, 1, 2 (byte, halfword, word) gives io_size 1, 2, 4 while io_req is high; io_we follows cpu_we.
- R5: On a write, io_wdata equals cpu_wdata shifted right by 8*cpu_addr[1:0], with the bits above the access size cleared.
- R6: On a read, cpu_rdata equals io_rdata masked to the access size and shifted left by 8*cpu_addr[1:0].
- R7: cpu_ready stays low until io_ack has been seen. It then rises for exactly one cycle, in the cycle after the one in which io_ack was high.
- R8: A read at 0xBFFFFFF0 raises ack_req for exactly one cycle and starts no port transaction. It waits for ack_vld, then returns ack_vec zero-extended in cpu_rdata[7:0].
- R9: A read of 0xBFFFFFF1..0xBFFFFFF3 completes with cpu_rdata zero, with no ack_req and no port transaction.
- R10: A write anywhere in 0xBFFFFFF0..0xBFFFFFF3 completes with cpu_ready, with no ack_req and no port transaction.
- R11: An access outside both regions gets no cpu_ready, no io_req and no ack_req, and cpu_rdata stays zero.
- R12: While io_req is high and io_ack low, io_req, io_port and io_wdata hold their values into the next cycle.
- R13: After reset, cpu_ready, io_req, ack_req and cpu_rdata are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_sparse | input | 1 | 1 selects sparse port mapping, 0 contiguous |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Write data in little-endian lane order |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready, zero otherwise |
| cpu_ready | output | 1 | One-cycle completion strobe |
| io_req | output | 1 | Port-bus transaction pending |
| io_we | output | 1 | Port-bus write |
| io_port | output | 16 | Port number |
| io_size | output | 3 | Byte count: 1, 2 or 4 |
| io_wdata | output | 32 | Right-justified write data |
| io_rdata | input | 32 | Right-justified read data, sampled with io_ack |
| io_ack | input | 1 | Port-bus completion |
| ack_req | output | 1 | One-cycle interrupt-acknowledge request |
| ack_vld | input | 1 | Interrupt vector valid |
| ack_vec | input | 8 | Interrupt vector |

## Verification
The bench goes after both ends of the I/O window, 0x807FFFFF inside and 0x80800000 outside. If either edge were decoded wrongly, the design would claim a foreign address or hang the processor. Sparse-mode offsets with all page bits and all group bits set are checked next to the same offsets in contiguous mode. This exposes a fold that shifts by the wrong amount or drops the top page bit. In the acknowledge region it tries the aligned read, the unaligned reads, the writes and the neighbouring words outside the region. A design that decoded the wrong offset would raise a stray interrupt request, and one that forwarded such accesses to the port bus would show a port transaction. Port and vector latencies are varied, so a design that raised ready before the acknowledge arrived is caught.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } xfer_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PORT = 2'd1,
      ST_VEC  = 2'd2,
      ST_RESP = 2'd3
   } brg_state_e;

   // Byte count on the port bus for a processor size code (3 treated as word)
   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_bytes = 3'd1;
         SZ_HALF: size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

   // Mask of the valid low bits for a size code
   function automatic logic [31:0] size_mask(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_mask = 32'h0000_00FF;
         SZ_HALF: size_mask = 32'h0000_FFFF;
         default: size_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/window_decode.sv
module window_decode #(
   parameter int                ADDR_W         = 32,
   parameter int                IO_SPAN_LOG2   = 23,
   parameter logic [ADDR_W-1:0] IO_BASE        = 32'h8000_0000,
   parameter int                ACK_SPAN_LOG2  = 2,
   parameter int                ACK_ALIGN_LOG2 = 4,
   parameter logic [ADDR_W-1:0] ACK_BASE       = 32'hBFFF_FFF0
) (
   input  logic [ADDR_W-1:0]       addr,
   output logic                    hit_io,
   output logic                    hit_ack,
   output logic                    vec_slot,
   output logic [IO_SPAN_LOG2-1:0] io_offset
);

   if (IO_SPAN_LOG2 >= ADDR_W || ACK_SPAN_LOG2 >= ADDR_W) begin : g_bad_span
      $error("window_decode: region span must be below the address width");
   end
   if (IO_BASE[IO_SPAN_LOG2-1:0] != '0) begin : g_bad_io_base
      $error("window_decode: I/O base must be aligned to its span");
   end
   if (ACK_BASE[ACK_ALIGN_LOG2-1:0] != '0) begin : g_bad_ack_base
      $error("window_decode: acknowledge base must be aligned");
   end
   if (ACK_ALIGN_LOG2 < ACK_SPAN_LOG2) begin : g_bad_align
      $error("window_decode: acknowledge alignment smaller than its span");
   end

   always_comb begin
      hit_io    = (addr[ADDR_W-1:IO_SPAN_LOG2] == IO_BASE[ADDR_W-1:IO_SPAN_LOG2]);
      hit_ack   = (addr[ADDR_W-1:ACK_SPAN_LOG2] == ACK_BASE[ADDR_W-1:ACK_SPAN_LOG2]);
      vec_slot  = hit_ack && (addr[ACK_ALIGN_LOG2-1:0] == '0);
      io_offset = addr[IO_SPAN_LOG2-1:0];
   end

endmodule

// File: rtl/port_xlate.sv
module port_xlate #(
   parameter int OFF_W      = 23,
   parameter int PORT_W     = 16,
   parameter int GROUP_LOG2 = 5,
   parameter int PAGE_LOG2  = 12,
   parameter bit SPARSE_EN  = 1'b1
) (
   input  logic [OFF_W-1:0]  offset,
   input  logic              sparse,
   output logic [PORT_W-1:0] port
);

   localparam int HI_W = PORT_W - GROUP_LOG2;

   if (PORT_W > OFF_W) begin : g_bad_port
      $error("port_xlate: port wider than window offset");
   end

   if (SPARSE_EN) begin : g_sparse
      if (PAGE_LOG2 + HI_W > OFF_W) begin : g_bad_fold
         $error("port_xlate: sparse fold exceeds window offset");
      end
      logic [PORT_W-1:0] folded;
      always_comb begin
         folded = {offset[PAGE_LOG2 +: HI_W], offset[GROUP_LOG2-1:0]};
         port   = sparse ? folded : offset[PORT_W-1:0];
      end
   end else begin : g_contig
      logic unused_sparse;
      always_comb begin
         unused_sparse = sparse;
         port          = offset[PORT_W-1:0];
      end
   end

endmodule

// File: rtl/lane_steer.sv
module lane_steer
   import isa_bridge_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = 2
) (
   input  logic [LANE_W-1:0] wr_lane,
   input  logic [1:0]        wr_size,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] wr_port_data,
   input  logic [LANE_W-1:0] rd_lane,
   input  logic [1:0]        rd_size,
   input  logic [DATA_W-1:0] rd_port_data,
   output logic [DATA_W-1:0] rd_data
);

   if (DATA_W != 32) begin : g_bad_width
      $error("lane_steer: size codes assume a 32-bit data path");
   end

   always_comb begin
      wr_port_data = (wr_data >> {wr_lane, 3'b000}) & size_mask(wr_size);
      rd_data      = (rd_port_data & size_mask(rd_size)) << {rd_lane, 3'b000};
   end

endmodule

// File: rtl/bridge_ctl.sv
module bridge_ctl
   import isa_bridge_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_req,
   input  logic cpu_we,
   input  logic hit_io,
   input  logic hit_ack,
   input  logic vec_slot,
   input  logic io_ack,
   input  logic ack_vld,
   output logic claim,
   output logic start_io,
   output logic cap_io,
   output logic cap_vec,
   output logic io_req,
   output logic ack_req,
   output logic cpu_ready
);

   brg_state_e state;
   logic       start_vec;
   logic       ack_req_q;

   always_comb begin
      claim     = (state == ST_IDLE) && cpu_req && (hit_io || hit_ack);
      start_io  = claim && hit_io;
      start_vec = claim && !hit_io && !cpu_we && vec_slot;
      cap_io    = (state == ST_PORT) && io_ack;
      cap_vec   = (state == ST_VEC) && ack_vld;
      io_req    = (state == ST_PORT);
      cpu_ready = (state == ST_RESP);
      ack_req   = ack_req_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ack_req_q <= 1'b0;
      end else begin
         ack_req_q <= start_vec;
         case (state)
            ST_IDLE: begin
               if (start_io)       state <= ST_PORT;
               else if (start_vec) state <= ST_VEC;
               else if (claim)     state <= ST_RESP;
            end
            ST_PORT: if (io_ack)  state <= ST_RESP;
            ST_VEC:  if (ack_vld) state <= ST_RESP;
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready); // R7
   AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !io_ack) |=> io_req); // R12
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |=> !ack_req); // R8
   AST_UNCLAIMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_IDLE) && cpu_req && !hit_io && !hit_ack)
         |=> (!io_req && !ack_req && !cpu_ready)); // R11
   AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_req && ack_req)); // R1

endmodule

// File: rtl/isa_io_bridge.sv
module isa_io_bridge
   import isa_bridge_pkg::*;
#(
   parameter int                ADDR_W         = 32,
   parameter int                DATA_W         = 32,
   parameter int                PORT_W         = 16,
   parameter int                VEC_W          = 8,
   parameter int                IO_SPAN_LOG2   = 23,
   parameter logic [ADDR_W-1:0] IO_BASE        = 32'h8000_0000,
   parameter int                ACK_SPAN_LOG2  = 2,
   parameter int                ACK_ALIGN_LOG2 = 4,
   parameter logic [ADDR_W-1:0] ACK_BASE       = 32'hBFFF_FFF0,
   parameter int                GROUP_LOG2     = 5,
   parameter int                PAGE_LOG2      = 12,
   parameter bit                SPARSE_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              map_sparse,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [1:0]        cpu_size,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              io_req,
   output logic              io_we,
   output logic [PORT_W-1:0] io_port,
   output logic [2:0]        io_size,
   output logic [DATA_W-1:0] io_wdata,
   input  logic [DATA_W-1:0] io_rdata,
   input  logic              io_ack,
   output logic              ack_req,
   input  logic              ack_vld,
   input  logic [VEC_W-1:0]  ack_vec
);

   localparam int LANES  = DATA_W / 8;
   localparam int LANE_W = $clog2(LANES);

   if (VEC_W > DATA_W) begin : g_bad_vec
      $error("isa_io_bridge: vector wider than data path");
   end

   logic                    hit_io, hit_ack, vec_slot;
   logic [IO_SPAN_LOG2-1:0] io_offset;
   logic [PORT_W-1:0]       port_n;
   logic [DATA_W-1:0]       wdata_n, rdata_n;
   logic                    claim, start_io, cap_io, cap_vec;

   logic [PORT_W-1:0]       port_q;
   logic [1:0]              size_q;
   logic                    we_q;
   logic [DATA_W-1:0]       wdata_q;
   logic [LANE_W-1:0]       lane_q;
   logic [DATA_W-1:0]       rdata_q;

   window_decode #(
      .ADDR_W(ADDR_W), .IO_SPAN_LOG2(IO_SPAN_LOG2), .IO_BASE(IO_BASE),
      .ACK_SPAN_LOG2(ACK_SPAN_LOG2), .ACK_ALIGN_LOG2(ACK_ALIGN_LOG2),
      .ACK_BASE(ACK_BASE)
   ) u_decode (
      .addr(cpu_addr), .hit_io(hit_io), .hit_ack(hit_ack),
      .vec_slot(vec_slot), .io_offset(io_offset)
   );

   port_xlate #(
      .OFF_W(IO_SPAN_LOG2), .PORT_W(PORT_W), .GROUP_LOG2(GROUP_LOG2),
      .PAGE_LOG2(PAGE_LOG2), .SPARSE_EN(SPARSE_EN)
   ) u_xlate (
      .offset(io_offset), .sparse(map_sparse), .port(port_n)
   );

   lane_steer #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_steer (
      .wr_lane(cpu_addr[LANE_W-1:0]), .wr_size(cpu_size), .wr_data(cpu_wdata),
      .wr_port_data(wdata_n),
      .rd_lane(lane_q), .rd_size(size_q), .rd_port_data(io_rdata),
      .rd_data(rdata_n)
   );

   bridge_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .hit_io(hit_io), .hit_ack(hit_ack), .vec_slot(vec_slot),
      .io_ack(io_ack), .ack_vld(ack_vld),
      .claim(claim), .start_io(start_io), .cap_io(cap_io), .cap_vec(cap_vec),
      .io_req(io_req), .ack_req(ack_req), .cpu_ready(cpu_ready)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         port_q  <= '0;
         size_q  <= SZ_BYTE;
         we_q    <= 1'b0;
         wdata_q <= '0;
         lane_q  <= '0;
         rdata_q <= '0;
      end else begin
         if (start_io) begin
            port_q  <= port_n;
            size_q  <= cpu_size;
            we_q    <= cpu_we;
            wdata_q <= wdata_n;
            lane_q  <= cpu_addr[LANE_W-1:0];
         end
         if (claim)        rdata_q <= '0;
         else if (cap_io)  rdata_q <= rdata_n;
         else if (cap_vec) rdata_q <= {{(DATA_W-VEC_W){1'b0}}, ack_vec};
      end
   end

   always_comb begin
      io_we     = io_req && we_q;
      io_port   = io_req ? port_q : '0;
      io_size   = io_req ? size_bytes(size_q) : 3'd0;
      io_wdata  = (io_req && we_q) ? wdata_q : '0;
      cpu_rdata = cpu_ready ? rdata_q : '0;
   end

   AST_PORT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !io_ack) |=> ($stable(io_port) && $stable(io_wdata))); // R12
   AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      io_req |-> (io_size == 3'd1 || io_size == 3'd2 || io_size == 3'd4)); // R4
   AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_ready |-> (cpu_rdata == '0)); // R11

endmodule

// File: tb/isa_io_bridge_test.sv
module isa_io_bridge_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        map_sparse = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [1:0]  cpu_size = '0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_ready;
   logic        io_req, io_we;
   logic [15:0] io_port;
   logic [2:0]  io_size;
   logic [31:0] io_wdata;
   logic [31:0] io_rdata = '0;
   logic        io_ack = 1'b0;
   logic        ack_req;
   logic        ack_vld = 1'b0;
   logic [7:0]  ack_vec = '0;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   isa_io_bridge uut (
      .clk(clk), .rst_n(rst_n), .map_sparse(map_sparse),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_ready(cpu_ready), .io_req(io_req), .io_we(io_we),
      .io_port(io_port), .io_size(io_size), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .io_ack(io_ack), .ack_req(ack_req),
      .ack_vld(ack_vld), .ack_vec(ack_vec)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] f_mask(input logic [1:0] sz);
      return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   function automatic logic [15:0] f_port(input logic [31:0] a, input bit sp);
      return sp ? {a[22:12], a[4:0]} : a[15:0];
   endfunction

   function automatic logic [2:0] f_bytes(input logic [1:0] sz);
      return (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;
   endfunction

   // 0 unclaimed, 1 port window, 2 vector read, 3 other acknowledge access
   function automatic int f_kind(input logic [31:0] a, input bit we);
      if (a[31:23] == 9'h100) return 1;
      if (a[31:2] == 30'h2FFF_FFFC) return (!we && a[1:0] == 2'b00) ? 2 : 3;
      return 0;
   endfunction

   task automatic xact(input bit we, input logic [31:0] a, input logic [1:0] sz,
                       input bit sp, input logic [31:0] wd, input int lat,
                       input logic [31:0] rd, input logic [7:0] vec);
      int  kind;
      int  waitc;
      int  pulses;
      int  limit;
      bit  served;
      bit  seen_io;
      bit  done;
      logic [31:0] got;
      kind = f_kind(a, we);
      waitc = 0; pulses = 0; served = 0; seen_io = 0; done = 0; got = '0;
      limit = (kind == 0) ? 6 : 40;
      map_sparse = sp; cpu_we = we; cpu_addr = a; cpu_size = sz;
      cpu_wdata = wd; cpu_req = 1'b1;
      for (int c = 0; c < limit && !done; c++) begin
         @(negedge clk);
         io_ack = 1'b0; ack_vld = 1'b0;
         if (ack_req) pulses++;
         if (cpu_ready) begin
            done = 1; got = cpu_rdata;
         end else begin
            if (io_req && !served) begin
               if (!seen_io) begin
                  seen_io = 1;
                  if (sp) check(io_port == f_port(a, sp), "R3", {16'h0, io_port}, {16'h0, f_port(a, sp)});
                  else    check(io_port == f_port(a, sp), "R2", {16'h0, io_port}, {16'h0, f_port(a, sp)});
                  check(io_size == f_bytes(sz) && io_we == we, "R4",
                        {28'h0, io_we, io_size}, {28'h0, we, f_bytes(sz)});
                  if (we) check(io_wdata == ((wd >> (8 * a[1:0])) & f_mask(sz)), "R5",
                                io_wdata, (wd >> (8 * a[1:0])) & f_mask(sz));
               end
               if (waitc == lat) begin io_ack = 1'b1; io_rdata = rd; served = 1; end
               else waitc++;
            end
            if (kind == 2 && pulses > 0 && !served) begin
               if (waitc == lat) begin ack_vld = 1'b1; ack_vec = vec; served = 1; end
               else waitc++;
            end
         end
      end
      case (kind)
         0: begin
            check(!done && !seen_io && pulses == 0, "R11",
                  {29'h0, done, seen_io, pulses != 0}, 32'h0);
            check(cpu_rdata == 32'h0, "R11", cpu_rdata, 32'h0);
         end
         1: begin
            check(done && served, "R7", {30'h0, done, served}, 32'h3);
            check(seen_io && pulses == 0, "R1", {31'h0, seen_io}, 32'h1);
            if (!we) check(got == ((rd & f_mask(sz)) << (8 * a[1:0])), "R6",
                           got, (rd & f_mask(sz)) << (8 * a[1:0]));
         end
         2: begin
            check(done && served && pulses == 1 && !seen_io, "R8",
                  {28'h0, done, served, seen_io, pulses == 1}, 32'hD);
            check(got == {24'h0, vec}, "R8", got, {24'h0, vec});
         end
         default: begin
            if (we) check(done && pulses == 0 && !seen_io, "R10",
                          {29'h0, done, pulses != 0, seen_io}, 32'h4);
            else begin
               check(done && pulses == 0 && !seen_io, "R9",
                     {29'h0, done, pulses != 0, seen_io}, 32'h4);
               check(got == 32'h0, "R9", got, 32'h0);
            end
         end
      endcase
      cpu_req = 1'b0; io_ack = 1'b0; ack_vld = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13: reset state
      check(!cpu_ready && !io_req && !ack_req && cpu_rdata == 0, "R13",
            {29'h0, cpu_ready, io_req, ack_req}, 32'h0);

      // Directed: window corners in both modes
      xact(1, 32'h8000_0398, 2'd0, 0, 32'h0000_00A5, 0, 32'h0, 8'h0);
      xact(0, 32'h8000_0399, 2'd0, 0, 32'h0, 2, 32'h1234_5677, 8'h0);
      xact(0, 32'h807F_F01F, 2'd0, 1, 32'h0, 1, 32'hCAFE_BABE, 8'h0);
      xact(0, 32'h807F_F01F, 2'd0, 0, 32'h0, 1, 32'hCAFE_BABE, 8'h0);
      xact(1, 32'h807F_FFFC, 2'd2, 1, 32'hDEAD_BEEF, 3, 32'h0, 8'h0);
      xact(1, 32'h8000_1002, 2'd1, 1, 32'h89AB_CDEF, 0, 32'h0, 8'h0);
      xact(0, 32'h8000_1002, 2'd1, 0, 32'h0, 0, 32'hFFFF_1357, 8'h0);
      xact(0, 32'h8080_0000, 2'd0, 0, 32'h0, 0, 32'h0, 8'h0);
      xact(0, 32'h7FFF_FFFC, 2'd2, 1, 32'h0, 0, 32'h0, 8'h0);

      // Directed: acknowledge region and its neighbours
      xact(0, 32'hBFFF_FFF0, 2'd0, 0, 32'h0, 0, 32'h0, 8'h2D);
      xact(0, 32'hBFFF_FFF0, 2'd2, 1, 32'h0, 4, 32'h0, 8'hF1);
      xact(0, 32'hBFFF_FFF1, 2'd0, 0, 32'h0, 0, 32'h0, 8'h55);
      xact(0, 32'hBFFF_FFF2, 2'd1, 0, 32'h0, 0, 32'h0, 8'h55);
      xact(1, 32'hBFFF_FFF0, 2'd2, 0, 32'h1111_2222, 0, 32'h0, 8'h0);
      xact(1, 32'hBFFF_FFF3, 2'd0, 0, 32'h0000_0033, 0, 32'h0, 8'h0);
      xact(0, 32'hBFFF_FFEC, 2'd2, 0, 32'h0, 0, 32'h0, 8'h0);
      xact(0, 32'hBFFF_FFF4, 2'd2, 0, 32'h0, 0, 32'h0, 8'h0);

      // Random port-window traffic
      for (int i = 0; i < 200; i++) begin
         logic [1:0]  sz;
         logic [31:0] a;
         sz = 2'($urandom_range(0, 2));
         a  = 32'h8000_0000 | ($urandom() & 32'h007F_FFFF);
         if (sz == 2'd1) a[0] = 1'b0;
         if (sz == 2'd2) a[1:0] = 2'b00;
         xact(1'($urandom()), a, sz, 1'($urandom()), $urandom(),
              int'($urandom_range(0, 3)), $urandom(), 8'h0);
      end
      // Random vector reads
      for (int i = 0; i < 10; i++) begin
         xact(0, 32'hBFFF_FFF0, 2'd2, 0, 32'h0, int'($urandom_range(0, 5)),
              32'h0, 8'($urandom()));
      end
      finish_run();
   end

endmodule